// File: doc/BRIEF.md
# Maskable Interrupt Status and Global Control Unit

This unit gathers single-cycle event pulses from a storage-card host controller's command engine, data engine and card-detect logic into a 32-bit raw status register. A mask register selects which raw bits may raise the interrupt. The masked view is the raw status gated by the mask. A single interrupt line is raised when any masked bit is set and the global interrupt enable is on. Software clears status bits by writing ones, either through the raw view or through the masked view.

The same unit holds the global control word. Three of its bits request a soft reset, a FIFO reset and a DMA reset. Each request bit stays set while its reset is running and drops by itself when that reset is over. The soft reset has a fixed length and empties the raw status. The FIFO and DMA resets end when their completion pulse arrives. Two other control bits are plain read/write: the interrupt enable and the DMA mode select.

Top module: `irq_status_unit`

## Requirements
- R1: After reset, the control, mask, raw and masked outputs are all zero and `irq_o` is low.
- R2: An event pulse on `evt_i` sets its raw bit at the next clock edge. Only bits 1 to 16, 30 and 31 can hold events (valid pattern 32'hC001_FFFE). Bit 0 and bits 17 to 29 always read 0.
- R3: A write with `wr_sel_i`=2 (raw view) clears every raw bit written as 1 and leaves the other raw bits unchanged.
- R4: A write with `wr_sel_i`=3 (masked view) clears the raw bits that are written as 1 and are also set in the mask. Raw bits written as 1 whose mask bit is 0 stay set.
- R5: If an event pulse and a clearing write land on the same bit in the same cycle, the bit ends up set.
- R6: A write with `wr_sel_i`=1 loads the mask with the written value ANDed with the valid pattern. The masked output always equals raw AND mask.
- R7: `irq_o` is high exactly when the masked status is nonzero and control bit 4 (interrupt enable) is set.
- R8: Writing 1 to control bit 0 (soft reset) sets it for exactly 4 cycles, after which it drops by itself. From the cycle after the bit is set until the cycle after it drops, the raw status reads zero and incoming events are discarded.
- R9: Writing 1 to control bit 1 (FIFO reset) or control bit 2 (DMA reset) sets that bit. It then stays set until `fifo_rst_done_i` or `dma_rst_done_i` respectively pulses. Writing 0 to any of the three reset bits has no effect.
- R10: Control bit 5 (DMA mode) and bit 4 are read/write. Control bit 3 and bits 6 to 31 always read 0. Register selects: 0 is control, 1 is mask, 2 is raw view, 3 is masked view.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| evt_i | input | 32 | Event pulses, one bit per status position |
| wr_en_i | input | 1 | Register write strobe |
| wr_sel_i | input | 2 | Register select: 0 control, 1 mask, 2 raw view, 3 masked view |
| wr_data_i | input | 32 | Write data |
| fifo_rst_done_i | input | 1 | FIFO reset completion pulse |
| dma_rst_done_i | input | 1 | DMA reset completion pulse |
| ctrl_o | output | 32 | Control register value |
| mask_o | output | 32 | Mask register value |
| raw_status_o | output | 32 | Raw status |
| masked_status_o | output | 32 | Raw status ANDed with mask |
| irq_o | output | 1 | Interrupt request |

## Verification
Two operations can hit the same status bit in one cycle: an event pulse setting it and a write clearing it. The bench provokes this by driving a pulse on bit 2 in the same cycle as a raw-view write that has a 1 in bit 2. It then checks at the next edge that the bit is still set and that the interrupt is asserted. A second overlap comes from the soft reset. Event pulses are driven while the reset runs, and the bench checks that they leave no trace once the reset bit drops.

// File: rtl/irq_stat_pkg.sv
package irq_stat_pkg;

    localparam int          REG_W     = 32;
    localparam logic [31:0] EVT_VALID = 32'hC001_FFFE;

    localparam int CTL_SRST = 0;
    localparam int CTL_FRST = 1;
    localparam int CTL_DRST = 2;
    localparam int CTL_IEN  = 4;
    localparam int CTL_DMA  = 5;

    typedef enum logic [1:0] {
        SEL_CTRL = 2'd0,
        SEL_MASK = 2'd1,
        SEL_RAW  = 2'd2,
        SEL_MSKD = 2'd3
    } reg_sel_e;

endpackage

// File: rtl/irq_raw_bank.sv
module irq_raw_bank #(
    parameter int          W     = 32,
    parameter logic [31:0] VALID = 32'hC001_FFFE
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] evt_i,
    input  logic [W-1:0] clr_i,
    input  logic         flush_i,
    output logic [W-1:0] raw_o
);

    typedef struct packed {
        logic [W-1:0] raw;
    } bank_t;

    bank_t        st_d, st_q;
    logic [W-1:0] nxt;

    for (genvar i = 0; i < W; i++) begin : g_bit
        if (VALID[i]) begin : g_live
            // a new event takes priority over a clear in the same cycle
            assign nxt[i] = flush_i ? 1'b0 : (evt_i[i] | (st_q.raw[i] & ~clr_i[i]));
        end else begin : g_tied
            assign nxt[i] = 1'b0;
        end
    end

    always_comb begin
        st_d     = st_q;
        st_d.raw = nxt;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign raw_o = st_q.raw;

endmodule

// File: rtl/irq_ctrl_reg.sv
module irq_ctrl_reg #(
    parameter int W           = 32,
    parameter int SRST_CYCLES = 4
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         wr_i,
    input  logic [W-1:0] wr_data_i,
    input  logic         fifo_done_i,
    input  logic         dma_done_i,
    output logic [W-1:0] ctrl_o
);
    import irq_stat_pkg::*;

    localparam int CNT_W = $clog2(SRST_CYCLES + 1);
    localparam logic [CNT_W-1:0] CNT_LOAD = CNT_W'(SRST_CYCLES - 1);

    typedef struct packed {
        logic             srst;
        logic             frst;
        logic             drst;
        logic             ien;
        logic             dma;
        logic [CNT_W-1:0] cnt;
    } ctrl_t;

    ctrl_t st_d, st_q;

    always_comb begin
        st_d = st_q;
        // soft reset: fixed length, reload on a fresh request
        if (wr_i && wr_data_i[CTL_SRST]) begin
            st_d.srst = 1'b1;
            st_d.cnt  = CNT_LOAD;
        end else if (st_q.srst) begin
            if (st_q.cnt == '0) st_d.srst = 1'b0;
            else                st_d.cnt  = st_q.cnt - 1'b1;
        end
        // FIFO and DMA resets: held until their completion pulse
        if (wr_i && wr_data_i[CTL_FRST]) st_d.frst = 1'b1;
        else if (fifo_done_i)            st_d.frst = 1'b0;
        if (wr_i && wr_data_i[CTL_DRST]) st_d.drst = 1'b1;
        else if (dma_done_i)             st_d.drst = 1'b0;
        if (wr_i) begin
            st_d.ien = wr_data_i[CTL_IEN];
            st_d.dma = wr_data_i[CTL_DMA];
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    always_comb begin
        ctrl_o           = '0;
        ctrl_o[CTL_SRST] = st_q.srst;
        ctrl_o[CTL_FRST] = st_q.frst;
        ctrl_o[CTL_DRST] = st_q.drst;
        ctrl_o[CTL_IEN]  = st_q.ien;
        ctrl_o[CTL_DMA]  = st_q.dma;
    end

endmodule

// File: rtl/irq_mask_out.sv
module irq_mask_out #(
    parameter int          W     = 32,
    parameter logic [31:0] VALID = 32'hC001_FFFE
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         wr_i,
    input  logic [W-1:0] wr_data_i,
    input  logic [W-1:0] raw_i,
    input  logic         ien_i,
    output logic [W-1:0] mask_o,
    output logic [W-1:0] masked_o,
    output logic         irq_o
);

    typedef struct packed {
        logic [W-1:0] mask;
    } mask_t;

    mask_t st_d, st_q;

    always_comb begin
        st_d = st_q;
        if (wr_i) st_d.mask = wr_data_i & VALID[W-1:0];
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign mask_o   = st_q.mask;
    assign masked_o = raw_i & st_q.mask;
    assign irq_o    = ien_i && (|masked_o);

endmodule

// File: rtl/irq_status_unit.sv
module irq_status_unit #(
    parameter int SRST_CYCLES = 4
) (
    input  logic        clk,
    input  logic        rst_n,
    input  logic [31:0] evt_i,
    input  logic        wr_en_i,
    input  logic [1:0]  wr_sel_i,
    input  logic [31:0] wr_data_i,
    input  logic        fifo_rst_done_i,
    input  logic        dma_rst_done_i,
    output logic [31:0] ctrl_o,
    output logic [31:0] mask_o,
    output logic [31:0] raw_status_o,
    output logic [31:0] masked_status_o,
    output logic        irq_o
);
    import irq_stat_pkg::*;

    reg_sel_e    sel;
    logic        wr_ctrl, wr_mask;
    logic [31:0] clr_vec;

    always_comb begin
        sel     = reg_sel_e'(wr_sel_i);
        wr_ctrl = wr_en_i && (sel == SEL_CTRL);
        wr_mask = wr_en_i && (sel == SEL_MASK);
        clr_vec = '0;
        if (wr_en_i && sel == SEL_RAW)  clr_vec = wr_data_i;
        if (wr_en_i && sel == SEL_MSKD) clr_vec = wr_data_i & mask_o;
    end

    irq_ctrl_reg #(.W(REG_W), .SRST_CYCLES(SRST_CYCLES)) ctrl_i (
        .clk(clk), .rst_n(rst_n), .wr_i(wr_ctrl), .wr_data_i(wr_data_i),
        .fifo_done_i(fifo_rst_done_i), .dma_done_i(dma_rst_done_i),
        .ctrl_o(ctrl_o)
    );

    irq_raw_bank #(.W(REG_W), .VALID(EVT_VALID)) raw_i (
        .clk(clk), .rst_n(rst_n), .evt_i(evt_i), .clr_i(clr_vec),
        .flush_i(ctrl_o[CTL_SRST]), .raw_o(raw_status_o)
    );

    irq_mask_out #(.W(REG_W), .VALID(EVT_VALID)) out_i (
        .clk(clk), .rst_n(rst_n), .wr_i(wr_mask), .wr_data_i(wr_data_i),
        .raw_i(raw_status_o), .ien_i(ctrl_o[CTL_IEN]),
        .mask_o(mask_o), .masked_o(masked_status_o), .irq_o(irq_o)
    );

endmodule

module irq_status_unit_chk #(
    parameter int SRST_CYCLES = 4
) (
    input logic        clk,
    input logic        rst_n,
    input logic [31:0] evt_i,
    input logic        wr_en_i,
    input logic [1:0]  wr_sel_i,
    input logic [31:0] wr_data_i,
    input logic [31:0] ctrl_o,
    input logic [31:0] mask_o,
    input logic [31:0] raw_status_o,
    input logic [31:0] masked_status_o,
    input logic        irq_o
);
    localparam logic [31:0] VLD = 32'hC001_FFFE;

    logic [7:0] srst_run;
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)         srst_run <= '0;
        else if (!ctrl_o[0]) srst_run <= '0;
        else if (srst_run != 8'hFF) srst_run <= srst_run + 1'b1;
    end

    // R2
    reserved_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (raw_status_o & ~VLD) == 32'h0);

    // R5
    event_wins_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !ctrl_o[0] |=> ((raw_status_o & $past(evt_i & VLD)) == $past(evt_i & VLD)));

    // R3
    raw_w1c_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en_i && wr_sel_i == 2'd2) |=>
        ((raw_status_o & $past(wr_data_i & ~evt_i)) == 32'h0));

    // R6
    masked_subset_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (masked_status_o & ~mask_o) == 32'h0);

    // R7
    irq_gate_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !ctrl_o[4] |-> !irq_o);

    // R8
    srst_flush_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ctrl_o[0] |=> (raw_status_o == 32'h0));

    // R8
    srst_len_chk: assert property (@(posedge clk) disable iff (!rst_n)
        srst_run <= 8'(SRST_CYCLES));

endmodule

bind irq_status_unit irq_status_unit_chk #(.SRST_CYCLES(SRST_CYCLES)) chk_i (
    .clk(clk), .rst_n(rst_n), .evt_i(evt_i), .wr_en_i(wr_en_i),
    .wr_sel_i(wr_sel_i), .wr_data_i(wr_data_i), .ctrl_o(ctrl_o),
    .mask_o(mask_o), .raw_status_o(raw_status_o),
    .masked_status_o(masked_status_o), .irq_o(irq_o)
);

// File: tb/irq_status_unit_tb_top.sv
module irq_status_unit_tb_top;

    localparam logic [31:0] VLD = 32'hC001_FFFE;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [31:0] evt_i = '0;
    logic        wr_en_i = 1'b0;
    logic [1:0]  wr_sel_i = '0;
    logic [31:0] wr_data_i = '0;
    logic        fifo_rst_done_i = 1'b0;
    logic        dma_rst_done_i = 1'b0;
    logic [31:0] ctrl_o, mask_o, raw_status_o, masked_status_o;
    logic        irq_o;

    always #4 clk = ~clk;

    irq_status_unit dut_i (
        .clk(clk), .rst_n(rst_n), .evt_i(evt_i), .wr_en_i(wr_en_i),
        .wr_sel_i(wr_sel_i), .wr_data_i(wr_data_i),
        .fifo_rst_done_i(fifo_rst_done_i), .dma_rst_done_i(dma_rst_done_i),
        .ctrl_o(ctrl_o), .mask_o(mask_o), .raw_status_o(raw_status_o),
        .masked_status_o(masked_status_o), .irq_o(irq_o)
    );

    typedef struct {
        string       tag;
        logic [31:0] raw;
        logic [31:0] mask;
        logic [31:0] ctrl;
        logic        irq;
    } item_t;

    item_t q[$];
    int    n_chk = 0;
    int    n_bad = 0;
    bit    done  = 0;

    // expected state, built from the requirements
    logic [31:0] m_raw = '0, m_mask = '0, m_ctrl = '0;
    int          m_cnt = 0;

    task automatic step(input logic [31:0] evt, input logic we, input logic [1:0] sel,
                        input logic [31:0] data, input logic fd, input logic dd,
                        input string tag);
        logic [31:0] clr, raw_n, mask_n, ctrl_n;
        item_t it;
        @(negedge clk);
        evt_i = evt; wr_en_i = we; wr_sel_i = sel; wr_data_i = data;
        fifo_rst_done_i = fd; dma_rst_done_i = dd;
        clr = '0;
        if (we && sel == 2'd2) clr = data;
        if (we && sel == 2'd3) clr = data & m_mask;
        raw_n  = m_ctrl[0] ? 32'h0 : (((m_raw & ~clr) | evt) & VLD);
        mask_n = (we && sel == 2'd1) ? (data & VLD) : m_mask;
        ctrl_n = m_ctrl;
        if (we && sel == 2'd0 && data[0]) begin
            ctrl_n[0] = 1'b1; m_cnt = 3;
        end else if (m_ctrl[0]) begin
            if (m_cnt == 0) ctrl_n[0] = 1'b0; else m_cnt--;
        end
        if (we && sel == 2'd0 && data[1]) ctrl_n[1] = 1'b1; else if (fd) ctrl_n[1] = 1'b0;
        if (we && sel == 2'd0 && data[2]) ctrl_n[2] = 1'b1; else if (dd) ctrl_n[2] = 1'b0;
        if (we && sel == 2'd0) begin
            ctrl_n[4] = data[4]; ctrl_n[5] = data[5];
        end
        m_raw = raw_n; m_mask = mask_n; m_ctrl = ctrl_n;
        it.tag  = tag;
        it.raw  = raw_n;
        it.mask = mask_n;
        it.ctrl = ctrl_n;
        it.irq  = ctrl_n[4] && (|(raw_n & mask_n));
        q.push_back(it);
    endtask

    task automatic idle(input string tag);
        step('0, 1'b0, 2'd0, '0, 1'b0, 1'b0, tag);
    endtask

    // monitor: compares after each edge, away from it
    initial begin
        forever begin
            @(posedge clk);
            #2;
            while (q.size() > 0) begin
                item_t it;
                it = q.pop_front();
                n_chk++;
                if (raw_status_o !== it.raw || mask_o !== it.mask ||
                    masked_status_o !== (it.raw & it.mask) ||
                    ctrl_o !== it.ctrl || irq_o !== it.irq) begin
                    n_bad++;
                    $display("FAIL %s: raw=%h mask=%h mskd=%h ctrl=%h irq=%b exp raw=%h mask=%h mskd=%h ctrl=%h irq=%b",
                             it.tag, raw_status_o, mask_o, masked_status_o, ctrl_o, irq_o,
                             it.raw, it.mask, it.raw & it.mask, it.ctrl, it.irq);
                end
            end
        end
    end

    initial begin
        #400000;
        if (!done) begin
            n_chk++; n_bad++;
            $display("FAIL watchdog: run did not finish, exp completion");
            $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
            $finish;
        end
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        idle("R1 reset state");
        step(32'hFFFF_FFFF, 1'b0, 2'd0, '0, 1'b0, 1'b0, "R2 all events, reserved stay 0");
        step('0, 1'b1, 2'd2, 32'h0000_00F0, 1'b0, 1'b0, "R3 raw view clear");
        step('0, 1'b1, 2'd1, 32'h0000_000C, 1'b0, 1'b0, "R6 mask load, enable off R7");
        step('0, 1'b1, 2'd0, 32'h0000_0010, 1'b0, 1'b0, "R7 enable raises irq");
        step('0, 1'b1, 2'd3, 32'h0000_0F0F, 1'b0, 1'b0, "R4 masked view clear");
        step(32'h0000_0004, 1'b1, 2'd2, 32'h0000_0004, 1'b0, 1'b0, "R5 event beats clear");
        step('0, 1'b1, 2'd0, 32'h0000_0013, 1'b0, 1'b0, "R8 soft reset start");
        step(32'h0000_0004, 1'b0, 2'd0, '0, 1'b0, 1'b0, "R8 event dropped 1");
        step(32'h0000_0008, 1'b0, 2'd0, '0, 1'b0, 1'b0, "R8 event dropped 2");
        step(32'h4000_0000, 1'b0, 2'd0, '0, 1'b0, 1'b0, "R8 event dropped 3");
        step(32'h8000_0000, 1'b0, 2'd0, '0, 1'b0, 1'b0, "R8 soft reset drops");
        step(32'h0000_0004, 1'b0, 2'd0, '0, 1'b0, 1'b0, "R8 events resume");
        step('0, 1'b1, 2'd0, 32'h0000_0010, 1'b0, 1'b0, "R9 write 0 keeps fifo reset");
        idle("R9 fifo reset held");
        step('0, 1'b0, 2'd0, '0, 1'b1, 1'b0, "R9 fifo done clears");
        step('0, 1'b1, 2'd0, 32'h0000_0014, 1'b0, 1'b0, "R9 dma reset set");
        step('0, 1'b0, 2'd0, '0, 1'b1, 1'b0, "R9 fifo done leaves dma reset");
        step('0, 1'b0, 2'd0, '0, 1'b0, 1'b1, "R9 dma done clears");
        step('0, 1'b1, 2'd0, 32'h0000_0020, 1'b0, 1'b0, "R10 dma mode, enable off");
        step('0, 1'b1, 2'd0, 32'hFFFF_FFC8, 1'b0, 1'b0, "R10 reserved control bits");
        step('0, 1'b1, 2'd1, 32'hFFFF_FFFF, 1'b0, 1'b0, "R6 mask valid bits only");
        step('0, 1'b1, 2'd0, 32'h0000_0010, 1'b0, 1'b0, "R7 irq on pending bit");
        step('0, 1'b1, 2'd3, 32'hFFFF_FFFF, 1'b0, 1'b0, "R4 masked clear all");
        idle("R7 irq low after clear");
        repeat (3) @(negedge clk);
        done = 1;
        $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
        $finish;
    end

endmodule